// File: doc/BRIEF.md
# Write-Zero-Clear Interrupt Flag Register

This block holds seven interrupt request flags in one 8-bit register of a small microcontroller's system-control space. Each flag is raised by hardware when a peripheral event happens. The events come from a low-power direct-transition controller, an ADC, a split compare-match timer (F), an edge/overflow timer (G), an up/down counter (C) and an asynchronous event counter. The block works out each event itself from simple inputs: mode and enable bits, busy bits, pin levels and live counter values.

Software reads the register to see which requests are pending. It writes a 0 to a flag to clear that flag. Writing 1 never sets a flag. Each flag also drives its own active-high request line towards the interrupt controller. Masking, vectoring and priority between requests are left to that controller.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset every flag is 0, the read value is 0x20 and every request line is 0.
- R2: A register write clears each flag whose written data bit is 0. A written 1 leaves that flag unchanged and never sets it.
- R3: When a hardware set event and a write of 0 hit the same flag in the same cycle, the flag ends up set.
- R4: Bit 5 holds no state. It always reads 1, writes to it have no effect, and request line 5 stays 0.
- R5: The ADC flag (bit 6) sets in the cycle after the converter busy input falls from 1 to 0.
- R6: The direct-transition flag (bit 7) sets when the sleep strobe, the direct-transition enable and the transition-taken input are all 1 in one cycle. It does not set if any of the three is 0.
- R7: Timer F high flag (bit 3). With the 16-bit mode input at 0, it sets when the high counter starts to equal the high compare value. With the mode input at 1, it sets only when the combined {high,low} counter starts to equal the combined compare value.
- R8: Timer F low flag (bit 2). It sets when the low counter starts to equal the low compare value, and only while the 16-bit mode input is 0.
- R9: Timer G flag (bit 4). It sets on an edge at its pin while the pin-select input is 1: a rising edge when the edge-select input is 0, a falling edge when it is 1. It also sets on an overflow pulse while the overflow enable is 1.
- R10: Timer C flag (bit 1). It sets when the counter goes from all-ones to zero while counting up, or from zero to all-ones while counting down. A jump the other way for the current direction does not set it.
- R11: Event counter flag (bit 0). It sets when the counter goes from all-ones to zero.
- R12: Request line i always equals flag i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data; a 0 in a flag bit clears that flag |
| rd_data | output | 8 | Read value: flags, with bit 5 at 1 |
| irq | output | 8 | Request line per flag; bit 5 is 0 |
| dt_sleep | input | 1 | Sleep instruction executed (strobe) |
| dt_enable | input | 1 | Direct-transition enable |
| dt_taken | input | 1 | A direct transition takes place |
| adc_busy | input | 1 | Converter busy/start bit |
| tf_mode16 | input | 1 | Timer F cascaded 16-bit mode |
| tf_cnt_hi | input | TF_W | Timer F high counter |
| tf_cnt_lo | input | TF_W | Timer F low counter |
| tf_cmp_hi | input | TF_W | Timer F high compare value |
| tf_cmp_lo | input | TF_W | Timer F low compare value |
| tg_pin_sel | input | 1 | Timer G pin set up as the timer input |
| tg_edge_fall | input | 1 | Timer G edge select: 1 selects the falling edge |
| tg_pin | input | 1 | Timer G input pin level |
| tg_ovf | input | 1 | Timer G counter overflow pulse |
| tg_ovie | input | 1 | Timer G overflow interrupt enable |
| tc_up | input | 1 | Timer C direction: 1 counts up |
| tc_cnt | input | TC_W | Timer C counter value |
| ec_cnt | input | EC_W | Asynchronous event counter value |

## Verification
The bench goes after a set event and a write of 0 landing in the same cycle. A design that lets the clear win loses an event and reads back 0 in that bit. It drives timer F through a mode switch in which the high halves still match but the low halves do not. A design that ignores the mode sets bit 3 too early, or sets bit 2 in 16-bit mode. Timer C runs through both wrap directions and through the jump that is wrong for each direction, which catches a detector that ignores direction. Writes of all ones and all zeros show whether software can set a flag or disturb bit 5.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
   localparam int REG_W   = 8;
   // bit positions; software decodes these
   localparam int POS_DT  = 7;
   localparam int POS_AD  = 6;
   localparam int POS_RSV = 5;
   localparam int POS_TG  = 4;
   localparam int POS_TFH = 3;
   localparam int POS_TFL = 2;
   localparam int POS_TC  = 1;
   localparam int POS_EC  = 0;
   localparam logic [REG_W-1:0] FLAG_MASK = 8'hDF;
   typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/irqf_edge.sv
module irqf_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise,
   output logic fall
);
   logic d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= RST_VAL;
      else        d_q <= d;
   end

   assign rise = d & ~d_q;
   assign fall = ~d & d_q;
endmodule

// File: rtl/irqf_wrap.sv
module irqf_wrap #(
   parameter int W     = 8,
   parameter bit BIDIR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic         up,
   output logic         wrap
);
   localparam logic [W-1:0] ALL1 = {W{1'b1}};
   localparam logic [W-1:0] ALL0 = {W{1'b0}};

   logic [W-1:0] prev_q;
   logic         valid_q;
   logic         wrap_up, wrap_dn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= ALL0;
         valid_q <= 1'b0;
      end else begin
         prev_q  <= cnt;
         valid_q <= 1'b1;
      end
   end

   generate
      if (BIDIR) begin : g_bidir
         assign wrap_up = valid_q & up  & (prev_q == ALL1) & (cnt == ALL0);
         assign wrap_dn = valid_q & ~up & (prev_q == ALL0) & (cnt == ALL1);
      end else begin : g_uponly
         logic up_unused;
         assign up_unused = up;
         assign wrap_up = valid_q & (prev_q == ALL1) & (cnt == ALL0);
         assign wrap_dn = 1'b0;
      end
   endgenerate

   assign wrap = wrap_up | wrap_dn;
endmodule

// File: rtl/irqf_event_gen.sv
module irqf_event_gen
   import irqf_pkg::*;
#(
   parameter int TF_W = 8,
   parameter int TC_W = 8,
   parameter int EC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dt_sleep,
   input  logic            dt_enable,
   input  logic            dt_taken,
   input  logic            adc_busy,
   input  logic            tf_mode16,
   input  logic [TF_W-1:0] tf_cnt_hi,
   input  logic [TF_W-1:0] tf_cnt_lo,
   input  logic [TF_W-1:0] tf_cmp_hi,
   input  logic [TF_W-1:0] tf_cmp_lo,
   input  logic            tg_pin_sel,
   input  logic            tg_edge_fall,
   input  logic            tg_pin,
   input  logic            tg_ovf,
   input  logic            tg_ovie,
   input  logic            tc_up,
   input  logic [TC_W-1:0] tc_cnt,
   input  logic [EC_W-1:0] ec_cnt,
   output reg_t            set_vec
);
   localparam int TF_FULL = 2 * TF_W;

   logic                ad_rise_unused, ad_fall;
   logic                tf_match_hi8, tf_match_lo8, tf_match16;
   logic                tf_cond_hi, tf_cond_lo;
   logic                tfh_rise, tfh_fall_unused, tfl_rise, tfl_fall_unused;
   logic                tg_rise, tg_fall, tg_edge_hit;
   logic                tc_wrap, ec_wrap;
   logic [TF_FULL-1:0]  tf_cnt_cat, tf_cmp_cat;

   // converter end of conversion = busy falling
   irqf_edge #(.RST_VAL(1'b0)) u_ad_edge (
      .clk(clk), .rst_n(rst_n), .d(adc_busy),
      .rise(ad_rise_unused), .fall(ad_fall)
   );

   // timer F compare: meaning depends on the cascade mode
   assign tf_cnt_cat   = {tf_cnt_hi, tf_cnt_lo};
   assign tf_cmp_cat   = {tf_cmp_hi, tf_cmp_lo};
   assign tf_match_hi8 = (tf_cnt_hi == tf_cmp_hi);
   assign tf_match_lo8 = (tf_cnt_lo == tf_cmp_lo);
   assign tf_match16   = (tf_cnt_cat == tf_cmp_cat);
   assign tf_cond_hi   = tf_mode16 ? tf_match16 : tf_match_hi8;
   assign tf_cond_lo   = ~tf_mode16 & tf_match_lo8;

   irqf_edge #(.RST_VAL(1'b0)) u_tfh_edge (
      .clk(clk), .rst_n(rst_n), .d(tf_cond_hi),
      .rise(tfh_rise), .fall(tfh_fall_unused)
   );
   irqf_edge #(.RST_VAL(1'b0)) u_tfl_edge (
      .clk(clk), .rst_n(rst_n), .d(tf_cond_lo),
      .rise(tfl_rise), .fall(tfl_fall_unused)
   );

   // timer G pin edge
   irqf_edge #(.RST_VAL(1'b0)) u_tg_edge (
      .clk(clk), .rst_n(rst_n), .d(tg_pin),
      .rise(tg_rise), .fall(tg_fall)
   );
   assign tg_edge_hit = tg_pin_sel & (tg_edge_fall ? tg_fall : tg_rise);

   // counters that wrap
   irqf_wrap #(.W(TC_W), .BIDIR(1'b1)) u_tc_wrap (
      .clk(clk), .rst_n(rst_n), .cnt(tc_cnt), .up(tc_up), .wrap(tc_wrap)
   );
   irqf_wrap #(.W(EC_W), .BIDIR(1'b0)) u_ec_wrap (
      .clk(clk), .rst_n(rst_n), .cnt(ec_cnt), .up(1'b1), .wrap(ec_wrap)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[POS_DT]  = dt_sleep & dt_enable & dt_taken;
      set_vec[POS_AD]  = ad_fall;
      set_vec[POS_TG]  = tg_edge_hit | (tg_ovf & tg_ovie);
      set_vec[POS_TFH] = tfh_rise;
      set_vec[POS_TFL] = tfl_rise;
      set_vec[POS_TC]  = tc_wrap;
      set_vec[POS_EC]  = ec_wrap;
   end
endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
   parameter int               W    = 8,
   parameter logic [W-1:0]     MASK = 8'hDF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] set,
   output logic [W-1:0] flags
);
   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         if (MASK[i]) begin : g_flag
            logic q;
            logic clr;
            assign clr = wr & ~wdata[i];
            // set has priority over clear
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      q <= 1'b0;
               else if (set[i]) q <= 1'b1;
               else if (clr)    q <= 1'b0;
            end
            assign flags[i] = q;
         end else begin : g_hole
            logic unused_in;
            assign unused_in = wdata[i] ^ set[i];
            assign flags[i]  = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
   import irqf_pkg::*;
#(
   parameter int TF_W = 8,
   parameter int TC_W = 8,
   parameter int EC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic [7:0]      bus_wdata,
   output logic [7:0]      rd_data,
   output logic [7:0]      irq,
   input  logic            dt_sleep,
   input  logic            dt_enable,
   input  logic            dt_taken,
   input  logic            adc_busy,
   input  logic            tf_mode16,
   input  logic [TF_W-1:0] tf_cnt_hi,
   input  logic [TF_W-1:0] tf_cnt_lo,
   input  logic [TF_W-1:0] tf_cmp_hi,
   input  logic [TF_W-1:0] tf_cmp_lo,
   input  logic            tg_pin_sel,
   input  logic            tg_edge_fall,
   input  logic            tg_pin,
   input  logic            tg_ovf,
   input  logic            tg_ovie,
   input  logic            tc_up,
   input  logic [TC_W-1:0] tc_cnt,
   input  logic [EC_W-1:0] ec_cnt
);
   generate
      if (TF_W < 1 || TF_W > 32) begin : g_bad_tf
         $error("irq_flag_reg: TF_W out of range");
      end
      if (TC_W < 2 || EC_W < 2) begin : g_bad_cnt
         $error("irq_flag_reg: counter widths must be at least 2");
      end
      if (FLAG_MASK[POS_RSV]) begin : g_bad_mask
         $error("irq_flag_reg: reserved bit must hold no flag");
      end
   endgenerate

   reg_t set_vec;
   reg_t flags;

   irqf_event_gen #(.TF_W(TF_W), .TC_W(TC_W), .EC_W(EC_W)) u_events (
      .clk(clk), .rst_n(rst_n),
      .dt_sleep(dt_sleep), .dt_enable(dt_enable), .dt_taken(dt_taken),
      .adc_busy(adc_busy),
      .tf_mode16(tf_mode16), .tf_cnt_hi(tf_cnt_hi), .tf_cnt_lo(tf_cnt_lo),
      .tf_cmp_hi(tf_cmp_hi), .tf_cmp_lo(tf_cmp_lo),
      .tg_pin_sel(tg_pin_sel), .tg_edge_fall(tg_edge_fall), .tg_pin(tg_pin),
      .tg_ovf(tg_ovf), .tg_ovie(tg_ovie),
      .tc_up(tc_up), .tc_cnt(tc_cnt), .ec_cnt(ec_cnt),
      .set_vec(set_vec)
   );

   irqf_flag_bank #(.W(REG_W), .MASK(FLAG_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
      .set(set_vec), .flags(flags)
   );

   assign rd_data = flags | ~FLAG_MASK;
   assign irq     = flags;
endmodule

// File: rtl/irqf_chk.sv
module irqf_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic [7:0] bus_wdata,
   input logic [7:0] rd_data,
   input logic [7:0] irq,
   input logic [7:0] set_vec
);
   logic [7:0] seen;
   logic [7:0] keep;
   assign seen = rd_data & 8'hDF;
   assign keep = bus_wr ? bus_wdata : 8'hFF;

   // R4
   rsv_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[5] && !irq[5]);

   // R12
   irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == seen);

   // R3
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec) |=> ((seen & $past(set_vec)) == $past(set_vec)));

   // R2
   no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen & ~(($past(seen) & $past(keep)) | $past(set_vec))) == 8'h00);

   // R2
   hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ((seen & $past(seen)) == $past(seen)));
endmodule

bind irq_flag_reg irqf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .rd_data(rd_data), .irq(irq), .set_vec(set_vec)
);

// File: tb/irq_flag_reg_tb.sv
module irq_flag_reg_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 0;
   logic [7:0] bus_wdata = 8'hFF;
   logic [7:0] rd_data, irq;
   logic dt_sleep = 0, dt_enable = 0, dt_taken = 0, adc_busy = 0;
   logic tf_mode16 = 0;
   logic [7:0] tf_cnt_hi = 0, tf_cnt_lo = 0, tf_cmp_hi = 8'hFF, tf_cmp_lo = 8'hFF;
   logic tg_pin_sel = 0, tg_edge_fall = 0, tg_pin = 0, tg_ovf = 0, tg_ovie = 0;
   logic tc_up = 1;
   logic [7:0] tc_cnt = 0, ec_cnt = 0;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_flag_reg u_dut (.*);

   // behavioural reference
   int m_flags = 0;
   int p_busy = 0, p_hi = 0, p_lo = 0, p_pin = 0, p_tc = 0, p_ec = 0, p_ok = 0;
   always @(posedge clk) begin
      int s, hi8, lo8, m16, ch, cl;
      if (!rst_n) begin
         m_flags = 0; p_busy = 0; p_hi = 0; p_lo = 0; p_pin = 0;
         p_tc = 0; p_ec = 0; p_ok = 0;
      end else begin
         s = 0;
         hi8 = (tf_cnt_hi == tf_cmp_hi);
         lo8 = (tf_cnt_lo == tf_cmp_lo);
         m16 = hi8 && lo8;
         ch  = tf_mode16 ? m16 : hi8;
         cl  = !tf_mode16 && lo8;
         if (dt_sleep && dt_enable && dt_taken) s += 128;
         if (p_busy == 1 && adc_busy == 0) s += 64;
         if ((tg_pin_sel && (tg_edge_fall ? (p_pin == 1 && tg_pin == 0)
                                          : (p_pin == 0 && tg_pin == 1)))
             || (tg_ovf && tg_ovie)) s += 16;
         if (ch == 1 && p_hi == 0) s += 8;
         if (cl == 1 && p_lo == 0) s += 4;
         if (p_ok == 1 && ((tc_up && p_tc == 255 && tc_cnt == 0) ||
                           (!tc_up && p_tc == 0 && tc_cnt == 255))) s += 2;
         if (p_ok == 1 && p_ec == 255 && ec_cnt == 0) s += 1;
         if (bus_wr) m_flags = m_flags & (bus_wdata | 8'h20);
         m_flags = (m_flags | s) & 8'hDF;
         p_busy = adc_busy; p_hi = ch; p_lo = cl; p_pin = tg_pin;
         p_tc = tc_cnt; p_ec = ec_cnt; p_ok = 1;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      cycles++;
      n_cmp++;
      if (rd_data !== 8'(m_flags | 8'h20) || irq !== 8'(m_flags)) begin
         n_bad++;
         $display("FAIL %s cycle %0d: rd=%h irq=%h expected rd=%h irq=%h",
                  cur_req, cycles, rd_data, irq, 8'(m_flags | 8'h20), 8'(m_flags));
      end
   end

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_rd(string r, logic [7:0] exp);
      n_cmp++;
      if (rd_data !== exp || irq !== (exp & 8'hDF)) begin
         n_bad++;
         $display("FAIL %s: rd=%h irq=%h expected rd=%h irq=%h",
                  r, rd_data, irq, exp, exp & 8'hDF);
      end
   endtask

   task automatic wr(logic [7:0] d);
      bus_wr = 1; bus_wdata = d; tick();
      bus_wr = 0; bus_wdata = 8'hFF;
   endtask

   initial begin
      tick(3);
      expect_rd("R1", 8'h20);
      rst_n = 1;
      tick(2);
      expect_rd("R1", 8'h20);

      cur_req = "R11";
      ec_cnt = 8'hFE; tick(); ec_cnt = 8'hFF; tick();
      expect_rd("R11", 8'h20);
      ec_cnt = 8'h00; tick();
      expect_rd("R11", 8'h21);

      cur_req = "R2";
      wr(8'hFF); expect_rd("R2", 8'h21);
      wr(8'hFE); expect_rd("R2", 8'h20);
      wr(8'hFF); expect_rd("R2", 8'h20);

      cur_req = "R10";
      tc_up = 1; tc_cnt = 8'hFF; tick(); tc_cnt = 8'h00; tick();
      expect_rd("R10", 8'h22);
      wr(8'hFD);
      tc_cnt = 8'hFF; tick();
      expect_rd("R10", 8'h20);
      tc_up = 0; tc_cnt = 8'h00; tick(); tc_cnt = 8'hFF; tick();
      expect_rd("R10", 8'h22);
      wr(8'h00);

      cur_req = "R7";
      tf_cmp_hi = 8'h12; tf_cmp_lo = 8'h34; tick();
      tf_cnt_hi = 8'h12; tick();
      expect_rd("R7", 8'h28);
      cur_req = "R8";
      tf_cnt_lo = 8'h34; tick();
      expect_rd("R8", 8'h2C);
      wr(8'hF3);
      cur_req = "R7";
      tf_cnt_lo = 8'h00; tf_mode16 = 1; tick(2);
      expect_rd("R7", 8'h20);
      tf_cnt_lo = 8'h34; tick();
      expect_rd("R8", 8'h28);
      wr(8'h00);

      cur_req = "R9";
      tg_pin = 1; tick();
      expect_rd("R9", 8'h20);
      tg_pin = 0; tg_pin_sel = 1; tick();
      tg_pin = 1; tick();
      expect_rd("R9", 8'h30);
      wr(8'hEF);
      tg_pin = 0; tick();
      expect_rd("R9", 8'h20);
      tg_edge_fall = 1; tg_pin = 1; tick(); tg_pin = 0; tick();
      expect_rd("R9", 8'h30);
      wr(8'h00);
      tg_ovf = 1; tick(); tg_ovf = 0;
      expect_rd("R9", 8'h20);
      tg_ovie = 1; tg_ovf = 1; tick(); tg_ovf = 0;
      expect_rd("R9", 8'h30);
      wr(8'h00);

      cur_req = "R5";
      adc_busy = 1; tick();
      expect_rd("R5", 8'h20);
      adc_busy = 0; tick();
      expect_rd("R5", 8'h60);

      cur_req = "R6";
      dt_sleep = 1; dt_taken = 1; tick(); dt_sleep = 0;
      expect_rd("R6", 8'h60);
      dt_enable = 1; dt_sleep = 1; tick(); dt_sleep = 0;
      expect_rd("R6", 8'hE0);

      cur_req = "R3";
      ec_cnt = 8'hFF; tick();
      ec_cnt = 8'h00; bus_wr = 1; bus_wdata = 8'h00; tick();
      bus_wr = 0; bus_wdata = 8'hFF;
      expect_rd("R3", 8'h21);

      cur_req = "R4";
      wr(8'hDF); expect_rd("R4", 8'h21);
      wr(8'h20); expect_rd("R4", 8'h20);
      expect_rd("R12", 8'h20);
      tick(2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule